// File: doc/BRIEF.md
# Lock-gated audio serial clock generator

This block produces the clocks of an audio serial link from a reference clock that runs at 256 times the sample rate. It derives a bit clock, a frame (word-select) clock and a master-clock output. The bit and frame clocks run only once a PLL-lock indication is present. Before that, and whenever lock is lost, they are held low, so a receiver never sees a partial pulse. The master-clock output has its own enable. It runs whenever the block is powered and that enable is set.

In the master role the block drives the bit and frame pins, and its output enables tell the pad ring to do so. In the slave role those pins belong to another device: the block releases them and drives only the master-clock output. A ratio select chooses 64 or 32 bit-clock periods per frame. Role and ratio changes made while running are held back until the next frame boundary. Power-up needs two enables, one for the PLL and one for the converter. If either is low, every output of the block is low.

Top module: `asc_clkgen`

## Requirements
- R1: While `rst` is high at a rising edge, all five outputs are low after that edge.
- R2: After any rising edge at which `pll_pwr_en` or `dac_pwr_en` is low, `mclk_out`, `bclk_out`, `fclk_out`, `bclk_oe` and `fclk_oe` are all low.
- R3: After any rising edge at which `mclk_en` is low, `mclk_out` is low.
- R4: While both power enables and `mclk_en` are high, `mclk_out` inverts at every reference edge (reference divided by two). The first edge of such a run drives it high.
- R5: Powered up in the master role without lock, `bclk_oe` and `fclk_oe` are high and `bclk_out` and `fclk_out` are low.
- R6: Call the first rising edge that samples lock high (while powered) edge 0, and count the edges after it as k. After edge k, the frame position is k mod 256. The frame clock equals bit 7 of that position, so it starts low for 128 reference cycles. The bit clock starts low, with no runt pulse.
- R7: With `bclk_wide` = 1 the bit clock equals position bit 1, which gives a period of 4 reference cycles and 64 per frame. With `bclk_wide` = 0 it equals position bit 2, which gives a period of 8 and 32 per frame.
- R8: The frame clock has a 50% duty cycle. It rises only in the same cycle in which the bit clock falls.
- R9: In the slave role (`role_master` = 0) `bclk_oe`, `fclk_oe`, `bclk_out` and `fclk_out` are low, while `mclk_out` still follows R3 and R4.
- R10: While running, new values of `role_master` and `bclk_wide` are taken only at the edge where the position wraps from 255 to 0. The whole new frame uses them.
- R11: After an edge that samples lock low, `bclk_out` and `fclk_out` are low. Re-lock starts a fresh frame as in R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, 256 times the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| pll_pwr_en | input | 1 | PLL power-up enable |
| dac_pwr_en | input | 1 | Converter power-up enable |
| role_master | input | 1 | 1 = master (drive bit/frame clocks), 0 = slave |
| bclk_wide | input | 1 | 1 = 64 bit clocks per frame, 0 = 32 |
| mclk_en | input | 1 | Master-clock output enable |
| pll_locked | input | 1 | PLL lock indication |
| mclk_out | output | 1 | Master-clock output |
| bclk_out | output | 1 | Bit clock value |
| bclk_oe | output | 1 | Bit-clock pad drive enable |
| fclk_out | output | 1 | Frame clock value |
| fclk_oe | output | 1 | Frame-clock pad drive enable |

## Verification
Every output comes from registers loaded at the rising edge that samples the inputs. An input change therefore shows up in the cycle after that edge, and the frame position advances one step per edge from the lock edge. The bench drives inputs on falling edges. For each driven cycle it pushes the outputs expected after the next rising edge into a queue. A monitor pops and compares them one time unit after that rising edge, so every comparison lines up with the single register stage.

// File: rtl/asc_pkg.sv
package asc_pkg;

    localparam int unsigned DEF_FRAME_LOG2  = 8;  // reference cycles per frame (256fs)
    localparam int unsigned DEF_WIDE_LOG2   = 6;  // 64 bit clocks per frame
    localparam int unsigned DEF_NARROW_LOG2 = 5;  // 32 bit clocks per frame

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } asc_state_e;

    typedef struct packed {
        logic master;
        logic wide;
    } asc_cfg_t;

    typedef struct packed {
        logic bclk;
        logic fclk;
        logic oe;
    } asc_pins_t;

    // Position bit whose value is the bit clock for a given bits-per-frame
    function automatic int unsigned bclk_tap(input int unsigned frame_log2,
                                             input int unsigned bits_log2);
        return frame_log2 - bits_log2 - 1;
    endfunction

endpackage

// File: rtl/asc_ctrl.sv
module asc_ctrl
    import asc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pwr_ok,
    input  logic     locked,
    input  asc_cfg_t cfg_in,
    input  logic     wrap,
    output logic     run,
    output logic     pwr_q,
    output asc_cfg_t cfg_q
);

    asc_state_e state;
    logic       gate;

    assign gate = pwr_ok & locked;
    assign run  = (state == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cfg_q <= '0;
            pwr_q <= 1'b0;
        end else begin
            pwr_q <= pwr_ok;
            case (state)
                ST_IDLE: begin
                    cfg_q <= cfg_in;
                    if (gate) state <= ST_RUN;
                end
                ST_RUN: begin
                    if (!gate) begin
                        state <= ST_IDLE;
                        cfg_q <= cfg_in;
                    end else if (wrap) begin
                        cfg_q <= cfg_in;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/asc_frame_counter.sv
module asc_frame_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         en,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    assign wrap = &cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/asc_mclk_div.sv
module asc_mclk_div #(
    parameter int unsigned DIV_LOG2 = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    output logic mclk
);

    localparam int unsigned W = DIV_LOG2 + 1;

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign mclk = cnt[W-1];

endmodule

// File: rtl/asc_clkgen.sv
module asc_clkgen
    import asc_pkg::*;
#(
    parameter int unsigned FRAME_LOG2    = DEF_FRAME_LOG2,
    parameter int unsigned WIDE_LOG2     = DEF_WIDE_LOG2,
    parameter int unsigned NARROW_LOG2   = DEF_NARROW_LOG2,
    parameter int unsigned MCLK_DIV_LOG2 = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic pll_pwr_en,
    input  logic dac_pwr_en,
    input  logic role_master,
    input  logic bclk_wide,
    input  logic mclk_en,
    input  logic pll_locked,
    output logic mclk_out,
    output logic bclk_out,
    output logic bclk_oe,
    output logic fclk_out,
    output logic fclk_oe
);

    localparam int unsigned TAP_WIDE   = bclk_tap(FRAME_LOG2, WIDE_LOG2);
    localparam int unsigned TAP_NARROW = bclk_tap(FRAME_LOG2, NARROW_LOG2);
    localparam int unsigned TAP_FRAME  = FRAME_LOG2 - 1;

    logic                  pwr_ok;
    logic                  run;
    logic                  pwr_q;
    logic                  wrap;
    logic [FRAME_LOG2-1:0] pos;
    asc_cfg_t              cfg_in;
    asc_cfg_t              cfg_q;
    asc_pins_t             pins;

    assign pwr_ok        = pll_pwr_en & dac_pwr_en;
    assign cfg_in.master = role_master;
    assign cfg_in.wide   = bclk_wide;

    asc_ctrl i_ctrl (
        .clk    (clk),
        .rst    (rst),
        .pwr_ok (pwr_ok),
        .locked (pll_locked),
        .cfg_in (cfg_in),
        .wrap   (wrap),
        .run    (run),
        .pwr_q  (pwr_q),
        .cfg_q  (cfg_q)
    );

    asc_frame_counter #(.W(FRAME_LOG2)) i_pos (
        .clk   (clk),
        .rst   (rst),
        .clear (~run),
        .en    (run),
        .cnt   (pos),
        .wrap  (wrap)
    );

    asc_mclk_div #(.DIV_LOG2(MCLK_DIV_LOG2)) i_mclk (
        .clk    (clk),
        .rst    (rst),
        .enable (pwr_ok & mclk_en),
        .mclk   (mclk_out)
    );

    // Pin decode from registered state only
    always_comb begin
        pins.oe   = pwr_q & cfg_q.master;
        pins.bclk = run & cfg_q.master &
                    (cfg_q.wide ? pos[TAP_WIDE] : pos[TAP_NARROW]);
        pins.fclk = run & cfg_q.master & pos[TAP_FRAME];
    end

    assign bclk_out = pins.bclk;
    assign fclk_out = pins.fclk;
    assign bclk_oe  = pins.oe;
    assign fclk_oe  = pins.oe;

endmodule

// File: rtl/asc_clkgen_chk.sv
module asc_clkgen_chk (
    input logic clk,
    input logic rst,
    input logic pll_pwr_en,
    input logic dac_pwr_en,
    input logic role_master,
    input logic mclk_en,
    input logic pll_locked,
    input logic mclk_out,
    input logic bclk_out,
    input logic bclk_oe,
    input logic fclk_out,
    input logic fclk_oe
);

    a_r2_powerdown_quiet: assert property (@(posedge clk) disable iff (rst)
        !(pll_pwr_en && dac_pwr_en) |=>
            (!mclk_out && !bclk_out && !fclk_out && !bclk_oe && !fclk_oe));

    a_r3_mclk_gated: assert property (@(posedge clk) disable iff (rst)
        !mclk_en |=> !mclk_out);

    a_r5_prelock_low: assert property (@(posedge clk) disable iff (rst)
        !pll_locked |=> (!bclk_out && !fclk_out));

    a_r5_master_drives: assert property (@(posedge clk) disable iff (rst)
        (pll_pwr_en && dac_pwr_en && role_master && !pll_locked) |=>
            (bclk_oe && fclk_oe));

    a_r8_fclk_rise_on_bclk_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(fclk_out) |-> $fell(bclk_out));

    a_r9_released_low: assert property (@(posedge clk) disable iff (rst)
        !bclk_oe |-> (!bclk_out && !fclk_out && !fclk_oe));

endmodule

bind asc_clkgen asc_clkgen_chk i_asc_clkgen_chk (
    .clk         (clk),
    .rst         (rst),
    .pll_pwr_en  (pll_pwr_en),
    .dac_pwr_en  (dac_pwr_en),
    .role_master (role_master),
    .mclk_en     (mclk_en),
    .pll_locked  (pll_locked),
    .mclk_out    (mclk_out),
    .bclk_out    (bclk_out),
    .bclk_oe     (bclk_oe),
    .fclk_out    (fclk_out),
    .fclk_oe     (fclk_oe)
);

// File: tb/test_asc_clkgen.sv
`timescale 1ns/1ps
module test_asc_clkgen;

    logic clk = 1'b0;
    logic rst, pll_pwr_en, dac_pwr_en, role_master, bclk_wide, mclk_en, pll_locked;
    logic mclk_out, bclk_out, bclk_oe, fclk_out, fclk_oe;

    always #2.5 clk = ~clk;

    asc_clkgen i_asc_clkgen (
        .clk(clk), .rst(rst), .pll_pwr_en(pll_pwr_en), .dac_pwr_en(dac_pwr_en),
        .role_master(role_master), .bclk_wide(bclk_wide), .mclk_en(mclk_en),
        .pll_locked(pll_locked), .mclk_out(mclk_out), .bclk_out(bclk_out),
        .bclk_oe(bclk_oe), .fclk_out(fclk_out), .fclk_oe(fclk_oe)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // Scoreboard queues: {mclk, bclk, bclk_oe, fclk, fclk_oe}
    logic [4:0] q_exp[$];
    string      q_tag[$];

    // Reference state built from the requirements
    bit m_run, m_master, m_wide, m_pwq, m_mclk;
    int m_pos;

    task automatic cycle(input logic r, input logic pe, input logic de,
                         input logic ms, input logic wd, input logic oe,
                         input logic lk, input string tag);
        bit pw, g, eb, ef, eo;
        @(negedge clk);
        rst = r; pll_pwr_en = pe; dac_pwr_en = de; role_master = ms;
        bclk_wide = wd; mclk_en = oe; pll_locked = lk;
        if (r) begin
            m_run = 0; m_master = 0; m_wide = 0; m_pwq = 0; m_mclk = 0; m_pos = 0;
        end else begin
            pw = pe & de;
            g  = pw & lk;
            m_mclk = (pw & oe) ? ~m_mclk : 1'b0;
            if (!m_run) begin
                m_master = ms; m_wide = wd;
                if (g) begin m_run = 1; m_pos = 0; end
            end else if (!g) begin
                m_run = 0; m_master = ms; m_wide = wd; m_pos = 0;
            end else begin
                m_pos = (m_pos + 1) % 256;
                if (m_pos == 0) begin m_master = ms; m_wide = wd; end
            end
            m_pwq = pw;
        end
        eo = m_pwq & m_master;
        eb = m_run & m_master & (m_wide ? m_pos[1] : m_pos[2]);
        ef = m_run & m_master & m_pos[7];
        q_exp.push_back({m_mclk, eb, eo, ef, eo});
        q_tag.push_back(tag);
    endtask

    task automatic repeat_cycle(input int n, input logic r, input logic pe,
                                input logic de, input logic ms, input logic wd,
                                input logic oe, input logic lk, input string tag);
        for (int i = 0; i < n; i++) cycle(r, pe, de, ms, wd, oe, lk, tag);
    endtask

    // Monitor: compare one time unit after each rising edge
    always @(posedge clk) begin
        #1;
        if (q_exp.size() > 0) begin
            logic [4:0] e;
            logic [4:0] a;
            string      t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            a = {mclk_out, bclk_out, bclk_oe, fclk_out, fclk_oe};
            n_checks++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL %s: {mclk,bclk,bclk_oe,fclk,fclk_oe} got %b expected %b",
                         t, a, e);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; pll_pwr_en = 0; dac_pwr_en = 0; role_master = 0;
        bclk_wide = 0; mclk_en = 0; pll_locked = 0;
        // R1: reset with everything requested on
        repeat_cycle(4, 1, 1, 1, 1, 1, 1, 1, "R1 reset");
        // R2: lock high but both power enables low
        repeat_cycle(5, 0, 0, 0, 1, 1, 1, 1, "R2 power-down");
        // R5 / R3: powered master, no lock, master clock disabled
        repeat_cycle(6, 0, 1, 1, 1, 1, 0, 0, "R5 prelock R3 mclk off");
        // R4: master clock enabled before lock
        repeat_cycle(6, 0, 1, 1, 1, 1, 1, 0, "R4 mclk toggle");
        // R6 / R7 / R8: lock in 64fs, two full frames and more
        repeat_cycle(600, 0, 1, 1, 1, 1, 1, 1, "R6 R7 R8 wide run");
        // R10: switch to 32fs mid-frame, applied at next wrap
        repeat_cycle(600, 0, 1, 1, 1, 0, 1, 1, "R10 R7 narrow switch");
        // R3: master clock disabled while locked
        repeat_cycle(20, 0, 1, 1, 1, 0, 0, 1, "R3 mclk off locked");
        // R9 / R10: slave request mid-frame
        repeat_cycle(400, 0, 1, 1, 0, 1, 1, 1, "R9 R10 slave");
        // back to master, then lose lock
        repeat_cycle(300, 0, 1, 1, 1, 1, 1, 1, "R10 master again");
        repeat_cycle(3, 0, 1, 1, 1, 1, 1, 0, "R11 lock lost");
        repeat_cycle(300, 0, 1, 1, 1, 1, 1, 1, "R11 relock fresh frame");
        // R2: only one enable dropped
        repeat_cycle(5, 0, 1, 0, 1, 1, 1, 1, "R2 dac off");
        repeat_cycle(5, 0, 0, 1, 1, 1, 1, 1, "R2 pll off");
        @(posedge clk);
        #2;
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule